// File: doc/BRIEF.md
# Tick-Driven PWM Generator with Bit-Selected Period

This block produces a single pulse-width-modulated output from a slow reference tick. An 8-bit counter advances by one on every tick. A 2-bit prescaler field chooses which counter bit ends the period. When the incremented count would set that bit, the counter returns to zero instead. The four settings give periods of 128, 64, 32 and 16 ticks. With a 32 kHz tick these are 250 Hz, 500 Hz, 1 kHz and 2 kHz.

The output is high while the counter's active low bits are below a 7-bit duty value. Software reaches the block through a byte-wide register port with two addresses, and both registers read back. There is no shadowing. A new prescaler keeps the current count, and a new duty value reaches the output at once. Software that wants clean transitions has to order its writes.

Top module: `pwm_tick_core`

## Requirements
- R1: A synchronous active-high `rst` clears both registers and the counter. After reset, both addresses read 0x00 and `pwm_out` is low.
- R2: Address 0 is the control register. Bit 7 is the enable and bits 1:0 are the prescaler p. A read returns these bits, and bits 6:2 read as 0.
- R3: Address 1 is the duty register. Bits 6:0 hold the duty value from 0 to 127. Bit 7 is not stored and reads as 0.
- R4: While enabled, the counter advances only in cycles where `tick` is 1. When the incremented value has bit (7−p) set, the counter loads 0 instead. From zero, this gives a period of 2^(7−p) ticks.
- R5: While enabled, `pwm_out` is 1 exactly when (counter AND (2^(7−p)−1)) is less than the duty value. This uses the register and counter values present in that cycle.
- R6: A duty value at or above the period keeps the output high for the whole period. With p=0 the largest duty, 127, gives 127 high ticks out of 128. With p=1 a duty of 64 gives a constant high output.
- R7: Writing the prescaler does not clear the counter. The count continues from its present value under the new reset bit.
- R8: A duty write shows on `pwm_out` in the cycle after the write, with no tick needed and no wait for a period boundary.
- R9: While enable is 0, `pwm_out` is low and the counter is held at 0. Setting enable starts counting from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Reference tick, one-cycle pulse per count |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 duty |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pwm_out | output | 1 | PWM output |

## Verification
The bench targets the p=0 full-duty limit, where an off-by-one compare would give 128 or 126 high ticks. It also checks the p=1 duty-64 case, which must stay high throughout; an inclusive compare would still work there, but a mask of the wrong width would drop the output. A prescaler switch in mid-count exposes a design that clears the counter, because the output level right after the switch comes out different. An immediate duty raise with no tick exposes a duty value that was wrongly buffered until the period boundary. Random register writes and ticks, with enable toggling, check the counter hold at zero and the stray reset bits beyond the active width against a cycle model.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;
  localparam int CNT_W = 8;
  localparam int PRE_W = 2;
  localparam int DATA_W = 8;

  // mask of the counter bits that take part in the compare
  function automatic logic [CNT_W-1:0] active_mask(input logic [PRE_W-1:0] p);
    return (CNT_W'(1) << (CNT_W - 1 - int'(p))) - CNT_W'(1);
  endfunction

  // period length in ticks for a prescaler value
  function automatic int unsigned period_ticks(input logic [PRE_W-1:0] p);
    return 32'd1 << (CNT_W - 1 - int'(p));
  endfunction

  // output level for a count, prescaler and duty value
  function automatic logic level_of(input logic [CNT_W-1:0] c,
                                    input logic [PRE_W-1:0] p,
                                    input logic [CNT_W-2:0] d);
    return (c & active_mask(p)) < {1'b0, d};
  endfunction
endpackage

// File: rtl/pwm_tick_regs.sv
module pwm_tick_regs #(
  parameter int DATA_W = pwm_tick_pkg::DATA_W,
  parameter int PRE_W  = pwm_tick_pkg::PRE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              en,
  output logic [PRE_W-1:0]  pre,
  output logic [DATA_W-2:0] duty,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - 1 - PRE_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      pre  <= '0;
      duty <= '0;
    end else if (we) begin
      if (!addr) begin
        en  <= wdata[DATA_W-1];
        pre <= wdata[PRE_W-1:0];
      end else begin
        duty <= wdata[DATA_W-2:0];
      end
    end
  end

  always_comb begin
    if (addr) rdata = {1'b0, duty};
    else      rdata = {en, {PAD_W{1'b0}}, pre};
  end
endmodule

// File: rtl/pwm_tick_counter.sv
module pwm_tick_counter #(
  parameter int CNT_W = pwm_tick_pkg::CNT_W,
  parameter int PRE_W = pwm_tick_pkg::PRE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [PRE_W-1:0] pre,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam int NSEL = 1 << PRE_W;

  logic [CNT_W-1:0] inc;
  logic [NSEL-1:0]  hit;

  assign inc = cnt + CNT_W'(1);

  // one candidate reset bit per prescaler setting
  for (genvar i = 0; i < NSEL; i++) begin : g_hit
    assign hit[i] = inc[CNT_W-1-i];
  end

  assign wrap = en & tick & hit[pre];

  always_ff @(posedge clk) begin
    if (rst || !en)  cnt <= '0;
    else if (wrap)   cnt <= '0;
    else if (tick)   cnt <= inc;
  end
endmodule

// File: rtl/pwm_tick_compare.sv
module pwm_tick_compare #(
  parameter int CNT_W = pwm_tick_pkg::CNT_W,
  parameter int PRE_W = pwm_tick_pkg::PRE_W
) (
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [PRE_W-1:0] pre,
  input  logic [CNT_W-2:0] duty,
  output logic             out
);
  assign out = en & pwm_tick_pkg::level_of(cnt, pre, duty);
endmodule

// File: rtl/pwm_tick_core.sv
module pwm_tick_core #(
  parameter int CNT_W = pwm_tick_pkg::CNT_W,
  parameter int PRE_W = pwm_tick_pkg::PRE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             pwm_out
);
  logic             ctrl_en;
  logic [PRE_W-1:0] pre_sel;
  logic [CNT_W-2:0] duty_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap_evt;

  pwm_tick_regs #(.DATA_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .en(ctrl_en), .pre(pre_sel), .duty(duty_q), .rdata(reg_rdata)
  );

  pwm_tick_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
    .clk(clk), .rst(rst), .en(ctrl_en), .tick(tick), .pre(pre_sel),
    .cnt(cnt_q), .wrap(wrap_evt)
  );

  pwm_tick_compare #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cmp (
    .en(ctrl_en), .cnt(cnt_q), .pre(pre_sel), .duty(duty_q), .out(pwm_out)
  );
endmodule

// File: rtl/pwm_tick_chk.sv
module pwm_tick_chk #(
  parameter int CNT_W = pwm_tick_pkg::CNT_W,
  parameter int PRE_W = pwm_tick_pkg::PRE_W
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             en,
  input logic [PRE_W-1:0] pre,
  input logic [CNT_W-2:0] duty,
  input logic [CNT_W-1:0] cnt,
  input logic             wrap,
  input logic             pwm_out
);
  // R9
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> !pwm_out);
  // R9
  off_cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0));
  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> (cnt == $past(cnt)));
  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));
  // R6
  full_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (en && (int'(duty) >= int'(pwm_tick_pkg::period_ticks(pre)))) |-> pwm_out);
  // R5
  zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (duty == '0) |-> !pwm_out);
endmodule

bind pwm_tick_core pwm_tick_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .en(ctrl_en), .pre(pre_sel),
  .duty(duty_q), .cnt(cnt_q), .wrap(wrap_evt), .pwm_out(pwm_out)
);

// File: tb/test_pwm_tick_core.sv
module test_pwm_tick_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       reg_we = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       pwm_out;

  int n_chk = 0;
  int n_err = 0;

  // bench model
  bit       m_en;
  bit [1:0] m_pre;
  bit [6:0] m_duty;
  bit [7:0] m_cnt;

  always #4 clk = ~clk;

  pwm_tick_core i_pwm_tick_core (
    .clk(clk), .rst(rst), .tick(tick), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  function automatic bit model_out();
    int span = 1 << (7 - m_pre);
    int low = m_cnt % span;
    return m_en && (low < int'(m_duty));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, model update after posedge, return at negedge
  task automatic step(input bit t, input bit w, input bit a, input bit [7:0] d);
    int nxt;
    tick = t; reg_we = w; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (!m_en) m_cnt = 0;
    else if (t) begin
      nxt = int'(m_cnt) + 1;
      if (((nxt >> (7 - m_pre)) & 1) != 0) m_cnt = 0;
      else m_cnt = 8'(nxt);
    end
    if (w) begin
      if (!a) begin m_en = d[7]; m_pre = d[1:0]; end
      else m_duty = d[6:0];
    end
    @(negedge clk);
    tick = 1'b0; reg_we = 1'b0;
  endtask

  task automatic check_out(input string req);
    check(pwm_out == model_out(), req, pwm_out, model_out());
  endtask

  task automatic check_rd(input bit a, input string req);
    int exp = a ? int'(m_duty) : ((m_en ? 128 : 0) + int'(m_pre));
    reg_addr = a;
    #1;
    check(int'(reg_rdata) == exp, req, reg_rdata, exp);
  endtask

  initial begin
    #1500000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int highs;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_en = 0; m_pre = 0; m_duty = 0; m_cnt = 0;

    // R1 reset state
    check_rd(1'b0, "R1");
    check_rd(1'b1, "R1");
    check(pwm_out == 1'b0, "R1", pwm_out, 0);

    // R2 / R3 read back with unused bits zero
    step(0, 1, 0, 8'hFE);
    check_rd(1'b0, "R2");
    step(0, 1, 1, 8'hC5);
    check_rd(1'b1, "R3");

    // R9 enable from 0, duty 3, p=3: first three ticks high
    step(0, 1, 0, 8'h00);
    step(0, 1, 1, 8'd3);
    step(0, 1, 0, 8'h83);
    check(pwm_out == 1'b1, "R9", pwm_out, 1);
    for (int i = 0; i < 20; i++) begin step(1, 0, 0, 0); check_out("R4"); end

    // R6 p=0 duty 127: 127 of 128 high
    step(0, 1, 0, 8'h00);
    step(0, 1, 1, 8'd127);
    step(0, 1, 0, 8'h80);
    highs = 0;
    for (int i = 0; i < 128; i++) begin highs += pwm_out; step(1, 0, 0, 0); end
    check(highs == 127, "R6", highs, 127);

    // R6 p=1 duty 64: constant high
    step(0, 1, 0, 8'h00);
    step(0, 1, 1, 8'd64);
    step(0, 1, 0, 8'h81);
    highs = 0;
    for (int i = 0; i < 64; i++) begin highs += pwm_out; step(1, 0, 0, 0); end
    check(highs == 64, "R6", highs, 64);

    // R7 prescaler switch keeps count: p=0 duty 10, count to 30, switch p=3
    step(0, 1, 0, 8'h00);
    step(0, 1, 1, 8'd10);
    step(0, 1, 0, 8'h80);
    for (int i = 0; i < 30; i++) step(1, 0, 0, 0);
    check(pwm_out == 1'b0, "R5", pwm_out, 0);
    step(0, 1, 0, 8'h83);
    check(pwm_out == 1'b0, "R7", pwm_out, 0);
    for (int i = 0; i < 40; i++) begin step(1, 0, 0, 0); check_out("R7"); end

    // R8 immediate duty change without a tick
    step(0, 1, 0, 8'h00);
    step(0, 1, 1, 8'd10);
    step(0, 1, 0, 8'h80);
    for (int i = 0; i < 20; i++) step(1, 0, 0, 0);
    check(pwm_out == 1'b0, "R8", pwm_out, 0);
    step(0, 1, 1, 8'd30);
    check(pwm_out == 1'b1, "R8", pwm_out, 1);

    // R9 disable forces low
    step(0, 1, 0, 8'h02);
    check(pwm_out == 1'b0, "R9", pwm_out, 0);
    step(1, 0, 0, 0);
    check_out("R9");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      bit [7:0] d = 8'($urandom);
      if (r < 70) step(1, 0, 0, 0);
      else if (r < 80) step(0, 1, 0, {($urandom_range(0, 7) != 0), d[6:0]});
      else if (r < 90) step(0, 1, 1, d);
      else step(0, 0, 0, 0);
      check_out("R5");
      if (r >= 95) check_rd(r[0], r[0] ? "R3" : "R2");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule